// File: doc/BRIEF.md
# UART Receive Holding and Error Status Register

This block is the receive-side holding register of a UART. Each time the receive shifter finishes a frame, it pulses a completion strobe. The block then latches up to nine data bits together with that frame's framing and parity indications. It also keeps a sticky overrun flag and an arbitration-lost flag. A CPU-style bus reads the result as one 16-bit word or as two bytes, with byte-lane selects.

Reading the low byte consumes the frame. The data-present flag drops, and the framing and parity flags drop with it. For that reason, software reads the upper byte first, or reads the whole halfword at once. The overrun flag is cleared by disabling the interface, either through the mode field or through receive enable. The arbitration-lost flag is the only bit that software can change, and software can only clear it.

Top module: `rxb_status_reg`

## Requirements
- R1: `bus_rdata[7:0]` shows bits 7..0 of the most recently completed frame, and `bus_rdata[8]` shows its ninth bit. `bus_rdata[10:9]` always reads 0.
- R2: `data_present` goes to 1 on the cycle after a `frame_done` pulse. It goes to 0 on the cycle after a low-byte read (`bus_rd` with `bus_be[0]`=1) in a cycle without `frame_done`. If `frame_done` and a low-byte read fall in the same cycle, `data_present` stays 1.
- R3: On each `frame_done`, the framing flag (`bus_rdata[13]`) loads from `frame_ferr` and the parity flag (`bus_rdata[14]`) loads from `frame_perr`.
- R4: A low-byte read without `frame_done` clears the framing and parity flags on the next cycle. A read of the upper byte only (`bus_be`=2'b10) changes neither these flags nor `data_present`.
- R5: The overrun flag (`bus_rdata[12]`) sets when `frame_done` arrives while `data_present` is 1 and the interface is enabled. In that case the data field takes the new frame.
- R6: The overrun flag reads 0 on the cycle after any cycle in which `mode`=3'b000 or `rx_en`=0, and it cannot set during such a cycle.
- R7: The arbitration flag (`bus_rdata[11]`) sets on an `arb_lost` pulse. A write with `bus_be[1]`=1 and `bus_wdata[11]`=0 clears it. A write with `bus_wdata[11]`=1, or a write without `bus_be[1]`, leaves it unchanged. A set in the same cycle as a clearing write wins.
- R8: Bus writes have no effect on any field other than the arbitration flag.
- R9: `bus_rdata[15]` is the OR of the overrun, framing and parity flags.
- R10: After reset, `data_present` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe: last bit of a frame received |
| frame_data | input | 9 | Received frame data bits |
| frame_ferr | input | 1 | Framing error indication for this frame |
| frame_perr | input | 1 | Parity error indication for this frame |
| arb_lost | input | 1 | One-cycle strobe: arbitration lost |
| mode | input | 3 | Serial mode field; 3'b000 means interface disabled |
| rx_en | input | 1 | Receive enable |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_be | input | 2 | Byte-lane selects: [0] low byte, [1] high byte |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Register read view |
| data_present | output | 1 | Unread frame is held |

## Verification
On every cycle, the assertions check how each flag moves: data-present set and clear, the framing-flag clear on a low-byte read, overrun set and clear, and the hold and set of the arbitration flag. They also check that a rising overrun shows in the summary bit. Only the bench scenarios can show the cases that depend on the order of accesses. These are reading the upper byte first to keep the error flags, which frame an overrun leaves in the data field, a frame that completes while the interface is disabled, and write patterns that are ignored.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;
  localparam int REG_W   = 16;
  localparam int FRAME_W = 9;
  localparam int MODE_W  = 3;
  localparam int ARB_POS = 11;
  localparam int OVR_POS = 12;
  localparam int FER_POS = 13;
  localparam int PER_POS = 14;
  localparam int SUM_POS = 15;

  typedef struct packed {
    logic arb;
    logic ovr;
    logic fer;
    logic per;
  } rxb_flags_t;

  function automatic logic err_summary(rxb_flags_t f);
    return f.ovr | f.fer | f.per;
  endfunction

  function automatic logic [REG_W-1:0] pack_view(logic [FRAME_W-1:0] d, rxb_flags_t f);
    logic [REG_W-1:0] w;
    w = '0;
    w[FRAME_W-1:0] = d;
    w[ARB_POS] = f.arb;
    w[OVR_POS] = f.ovr;
    w[FER_POS] = f.fer;
    w[PER_POS] = f.per;
    w[SUM_POS] = err_summary(f);
    return w;
  endfunction
endpackage

// File: rtl/rxb_data_hold.sv
`timescale 1ns/1ps
module rxb_data_hold #(
  parameter int FRAME_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               lo_rd,
  output logic [FRAME_W-1:0] data_q,
  output logic               present_q
);
  logic consume;
  assign consume = lo_rd && !frame_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      present_q <= 1'b0;
    end else begin
      if (frame_done) begin
        data_q    <= frame_data;
        present_q <= 1'b1;
      end else if (consume) begin
        present_q <= 1'b0;
      end
    end
  end

  a_r2_present_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> present_q);
  a_r2_present_clear: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !present_q);
  a_r1_data_capture: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (data_q == $past(frame_data)));
endmodule

// File: rtl/rxb_err_flags.sv
`timescale 1ns/1ps
module rxb_err_flags
  import rxb_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              frame_ferr,
  input  logic              frame_perr,
  input  logic              present_q,
  input  logic              lo_rd,
  input  logic [MODE_W-1:0] mode,
  input  logic              rx_en,
  input  logic              arb_lost,
  input  logic              arb_clr_wr,
  output rxb_flags_t        flags_q
);
  logic if_off, ovr_set, err_wipe;
  assign if_off   = (mode == '0) || !rx_en;
  assign ovr_set  = frame_done && present_q && !if_off;
  assign err_wipe = lo_rd && !frame_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (if_off)       flags_q.ovr <= 1'b0;
      else if (ovr_set) flags_q.ovr <= 1'b1;

      if (frame_done) begin
        flags_q.fer <= frame_ferr;
        flags_q.per <= frame_perr;
      end else if (err_wipe) begin
        flags_q.fer <= 1'b0;
        flags_q.per <= 1'b0;
      end

      if (arb_lost)        flags_q.arb <= 1'b1;
      else if (arb_clr_wr) flags_q.arb <= 1'b0;
    end
  end

  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && present_q && rx_en && (mode != '0)) |=> flags_q.ovr);
  a_r6_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || (mode == '0)) |=> !flags_q.ovr);
  a_r4_err_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && !frame_done) |=> (!flags_q.fer && !flags_q.per));
  a_r3_err_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (flags_q.fer == $past(frame_ferr)) && (flags_q.per == $past(frame_perr)));
  a_r7_arb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.arb && !arb_clr_wr) |=> flags_q.arb);
  a_r7_arb_set: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> flags_q.arb);
endmodule

// File: rtl/rxb_status_reg.sv
`timescale 1ns/1ps
module rxb_status_reg
  import rxb_pkg::*;
#(
  parameter int FW = rxb_pkg::FRAME_W,
  parameter int MW = rxb_pkg::MODE_W,
  parameter int RW = rxb_pkg::REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [FW-1:0] frame_data,
  input  logic          frame_ferr,
  input  logic          frame_perr,
  input  logic          arb_lost,
  input  logic [MW-1:0] mode,
  input  logic          rx_en,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [RW/8-1:0] bus_be,
  input  logic [RW-1:0] bus_wdata,
  output logic [RW-1:0] bus_rdata,
  output logic          data_present
);
  localparam int ARB_LANE = ARB_POS / 8;

  logic          lo_rd, arb_clr_wr;
  logic [FW-1:0] data_q;
  rxb_flags_t    flags_q;

  assign lo_rd      = bus_rd && bus_be[0];
  assign arb_clr_wr = bus_wr && bus_be[ARB_LANE] && !bus_wdata[ARB_POS];

  rxb_data_hold #(.FRAME_W(FW)) u_hold (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .lo_rd(lo_rd), .data_q(data_q), .present_q(data_present)
  );

  rxb_err_flags #(.MODE_W(MW)) u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_ferr(frame_ferr),
    .frame_perr(frame_perr), .present_q(data_present), .lo_rd(lo_rd), .mode(mode),
    .rx_en(rx_en), .arb_lost(arb_lost), .arb_clr_wr(arb_clr_wr), .flags_q(flags_q)
  );

  assign bus_rdata = pack_view(data_q, flags_q);

  a_r9_sum_follows_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[OVR_POS]) |-> bus_rdata[SUM_POS]);
endmodule

// File: tb/tb_rxb_status_reg.sv
`timescale 1ns/1ps
module tb_rxb_status_reg;
  logic clk = 0, rst_n = 0;
  logic frame_done = 0, frame_ferr = 0, frame_perr = 0, arb_lost = 0;
  logic [8:0] frame_data = '0;
  logic [2:0] mode = 3'b101;
  logic rx_en = 1, bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic data_present;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int  m_data;
  bit  m_known, m_pres, m_arb, m_ovr, m_fer, m_per;

  always #2.5 clk = ~clk;

  rxb_status_reg dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .frame_ferr(frame_ferr), .frame_perr(frame_perr), .arb_lost(arb_lost),
    .mode(mode), .rx_en(rx_en), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_present(data_present)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_known = 0; m_pres = 0; m_arb = 0; m_ovr = 0; m_fer = 0; m_per = 0; m_data = 0;
    end else begin
      bit enabled, was_present;
      enabled = (mode != 0) && rx_en;
      was_present = m_pres;
      if (!enabled) m_ovr = 0;
      else if (frame_done && was_present) m_ovr = 1;
      if (frame_done) begin
        m_data = frame_data; m_known = 1; m_pres = 1;
        m_fer = frame_ferr; m_per = frame_perr;
      end else if (bus_rd && bus_be[0]) begin
        m_pres = 0; m_fer = 0; m_per = 0;
      end
      if (arb_lost) m_arb = 1;
      else if (bus_wr && bus_be[1] && !bus_wdata[11]) m_arb = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_known) chk(bus_rdata[8:0], m_data, "R1 data");
      chk(bus_rdata[10:9], 0, "R1 unused");
      chk(data_present, m_pres, "R2 present");
      chk(bus_rdata[13], m_fer, "R3/R4 framing");
      chk(bus_rdata[14], m_per, "R3/R4 parity");
      chk(bus_rdata[12], m_ovr, "R5/R6 overrun");
      chk(bus_rdata[11], m_arb, "R7 arb");
      chk(bus_rdata[15], m_ovr | m_fer | m_per, "R9 summary");
    end
  end

  task automatic idle();
    frame_done = 0; arb_lost = 0; bus_rd = 0; bus_wr = 0; bus_be = 0;
  endtask

  // each task: drive just after a negedge, hold one cycle, return at next negedge
  task automatic frame(input int d, input bit fe, input bit pe);
    frame_data = d[8:0]; frame_ferr = fe; frame_perr = pe; frame_done = 1;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [1:0] be);
    bus_rd = 1; bus_be = be; @(negedge clk); idle();
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    bus_wr = 1; bus_be = be; bus_wdata = d; @(negedge clk); idle();
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    @(negedge clk);
    // R10: reset state
    chk(data_present, 0, "R10 present");
    chk(bus_rdata[15:11], 0, "R10 flags");
    rst_n = 1;
    wait_cyc(2);
    chk(bus_rdata[15:11], 0, "R10 flags after release");

    // R1/R2 basic frame
    frame(9'h1A5, 0, 0);
    chk(bus_rdata[8:0], 9'h1A5, "R1 capture");
    chk(data_present, 1, "R2 set");
    rd(2'b10);
    chk(data_present, 1, "R4 high-only read keeps present");
    rd(2'b01);
    chk(data_present, 0, "R2 clear on low read");

    // R3/R4 framing error kept through upper read, lost after low read
    frame(9'h055, 1, 0);
    chk(bus_rdata[13], 1, "R3 framing load");
    chk(bus_rdata[15], 1, "R9 summary from framing");
    rd(2'b10);
    chk(bus_rdata[13], 1, "R4 framing kept on high read");
    rd(2'b01);
    chk(bus_rdata[13], 0, "R4 framing cleared");
    frame(9'h0AA, 0, 1);
    chk(bus_rdata[14], 1, "R3 parity load");
    rd(2'b11);
    chk(bus_rdata[14], 0, "R4 parity cleared by halfword read");

    // R2 frame coinciding with low read
    frame(9'h011, 0, 0);
    frame_data = 9'h022; frame_done = 1; bus_rd = 1; bus_be = 2'b01;
    @(negedge clk); idle();
    chk(data_present, 1, "R2 frame wins over read");
    chk(bus_rdata[8:0], 9'h022, "R1 new frame");
    chk(bus_rdata[12], 1, "R5 overrun from coinciding frame");

    // R6 clear by rx_en, then R5 again with new data
    rx_en = 0; wait_cyc(1); rx_en = 1;
    wait_cyc(1);
    chk(bus_rdata[12], 0, "R6 cleared by rx_en");
    frame(9'h1F0, 0, 0);
    chk(bus_rdata[12], 1, "R5 overrun set");
    chk(bus_rdata[8:0], 9'h1F0, "R5 new frame kept");
    chk(bus_rdata[15], 1, "R9 summary from overrun");
    mode = 3'b000; wait_cyc(1);
    chk(bus_rdata[12], 0, "R6 cleared by mode");
    frame(9'h033, 0, 0);
    chk(bus_rdata[12], 0, "R6 no set while disabled");
    mode = 3'b100;
    rd(2'b01);

    // R7 arbitration flag
    arb_lost = 1; @(negedge clk); idle();
    chk(bus_rdata[11], 1, "R7 set");
    wr(2'b11, 16'hFFFF);
    chk(bus_rdata[11], 1, "R7 write one ignored");
    wr(2'b01, 16'h0000);
    chk(bus_rdata[11], 1, "R7 low-lane write ignored");
    arb_lost = 1; bus_wr = 1; bus_be = 2'b10; bus_wdata = 16'h0000;
    @(negedge clk); idle();
    chk(bus_rdata[11], 1, "R7 set wins");
    wr(2'b10, 16'h0000);
    chk(bus_rdata[11], 0, "R7 cleared by write zero");

    // R8 writes ignored elsewhere
    frame(9'h0C3, 1, 1);
    wr(2'b11, 16'hF7FF);
    wr(2'b11, 16'h0000);
    chk(bus_rdata[8:0], 9'h0C3, "R8 data untouched");
    chk(bus_rdata[14:13], 2'b11, "R8 flags untouched");
    chk(data_present, 1, "R8 present untouched");
    rd(2'b01);
    wait_cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule